// File: doc/BRIEF.md
# DMA Bus Hold and Interrupt Suspend Controller

This block sits between a DMA engine and the CPU's data bus arbitration. When the engine has work, the controller raises a hold request toward the CPU. Once the CPU acknowledges, the controller grants the bus to the engine. A transfer that begins while the CPU is servicing an ordinary interrupt is still accepted. Low-priority interrupts cannot take the bus back until the engine reports the transfer done.

Only two conditions can take the bus back before the transfer finishes: a non-maskable interrupt, or a pending interrupt whose level is strictly above a programmable suppress threshold. Even then the bus is not released mid-unit. The controller waits for the engine's unit-boundary pulse, then drops the hold request and the grant together and enters a suspended state. The controller remembers the unfinished transfer. It asks for the bus again by itself once the interrupt condition has cleared and the CPU has let its acknowledge fall.

Top module: `dma_bus_hold_ctrl`

The FSM has four states:
- IDLE: no request.
- ASK: hold request raised, waiting for the acknowledge.
- OWN: the bus is granted to the engine.
- PAUSE: the transfer is suspended.

It has these transitions:
- IDLE→ASK: the engine requests and the acknowledge is low.
- ASK→OWN: the acknowledge is seen high.
- ASK→PAUSE: preemption occurs before the grant.
- OWN→IDLE: the engine reports done.
- OWN→PAUSE: preemption is present at a unit boundary.
- PAUSE→ASK: preemption has cleared and the acknowledge is low.

## Requirements
- R1: While reset is asserted, and on leaving it, hold_req_o, grant_o and suspended_o are all 0.
- R2: In IDLE, if xfer_req_i is high and hold_ack_i is low, hold_req_o is 1 after the next clock edge. grant_o rises on the edge after hold_ack_i is first sampled at 1.
- R3: grant_o is 1 only while hold_req_o is 1. When the bus is released, both outputs fall after the same clock edge.
- R4: An interrupt level less than or equal to supp_level_i, with nmi_i low, has no effect on an active transfer. This holds even when a unit boundary occurs.
- R5: Preemption is nmi_i high, or irq_level_i greater than supp_level_i, compared as unsigned numbers. During an active transfer, preemption releases the bus only on an edge where unit_end_i is 1. After that edge, hold_req_o and grant_o are 0 and suspended_o is 1. Without unit_end_i, the grant is kept.
- R6: Preemption while the hold request is still waiting for the acknowledge withdraws the request after the next edge, and suspended_o becomes 1.
- R7: While preemption persists, suspended_o stays 1. The suspended transfer is kept even if xfer_req_i falls.
- R8: From suspension, once preemption is gone and hold_ack_i is 0, hold_req_o is 1 and suspended_o is 0 after the next edge. The grant then follows the acknowledge as in R2.
- R9: xfer_done_i high during an active transfer returns all outputs to 0 after the next edge. This takes priority over a simultaneous boundary with preemption.
- R10: A new request, or a resume, is not raised while hold_ack_i is still 1 from the previous ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req_i | input | 1 | Engine has a transfer to run (level) |
| unit_end_i | input | 1 | Engine is at a transfer-unit boundary this cycle |
| xfer_done_i | input | 1 | Engine has finished the transfer |
| hold_ack_i | input | 1 | CPU acknowledges the bus hold |
| nmi_i | input | 1 | Non-maskable interrupt pending |
| irq_level_i | input | LVL_W | Level of the pending interrupt (larger is more urgent) |
| supp_level_i | input | LVL_W | Programmed hold-suppress threshold |
| hold_req_o | output | 1 | Bus hold request to the CPU |
| grant_o | output | 1 | Bus granted to the DMA engine |
| suspended_o | output | 1 | Transfer suspended by an interrupt |

## Verification
Every output is a direct decode of the state register, so a wrong state shows at the ports one edge after the input that caused it.

- A missed boundary shows as suspended_o rising while the grant is held, or the grant falling without unit_end_i.
- A lost suspended transfer shows as hold_req_o never returning after the interrupt clears.
- A stale-acknowledge error shows as grant_o rising without a new acknowledge.

The scoreboard compares all three outputs after every edge, so each of these faults is caught on the edge where it first appears.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ASK   = 2'd1,
        ST_OWN   = 2'd2,
        ST_PAUSE = 2'd3
    } hold_state_e;
endpackage

// File: rtl/dma_preempt_cmp.sv
module dma_preempt_cmp #(
    parameter int LVL_W = 4
) (
    input  logic             nmi_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] supp_level_i,
    output logic             preempt_o
);
    // Strictly above the threshold preempts; equal does not.
    logic above;
    always_comb begin
        above     = (irq_level_i > supp_level_i);
        preempt_o = nmi_i | above;
    end
endmodule

// File: rtl/dma_hold_fsm.sv
module dma_hold_fsm
    import dma_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req_i,
    input  logic unit_end_i,
    input  logic xfer_done_i,
    input  logic hold_ack_i,
    input  logic preempt_i,
    output logic hold_req_o,
    output logic grant_o,
    output logic suspended_o
);
    hold_state_e state_q, state_d;

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_req_i && !hold_ack_i) state_d = ST_ASK;
            end
            ST_ASK: begin
                if (preempt_i)       state_d = ST_PAUSE;
                else if (hold_ack_i) state_d = ST_OWN;
            end
            ST_OWN: begin
                if (xfer_done_i)                 state_d = ST_IDLE;
                else if (unit_end_i && preempt_i) state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (!preempt_i && !hold_ack_i) state_d = ST_ASK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        hold_req_o  = 1'b0;
        grant_o     = 1'b0;
        suspended_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ASK:   hold_req_o = 1'b1;
            ST_OWN: begin
                hold_req_o = 1'b1;
                grant_o    = 1'b1;
            end
            ST_PAUSE: suspended_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/dma_bus_hold_ctrl.sv
module dma_bus_hold_ctrl #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_req_i,
    input  logic             unit_end_i,
    input  logic             xfer_done_i,
    input  logic             hold_ack_i,
    input  logic             nmi_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] supp_level_i,
    output logic             hold_req_o,
    output logic             grant_o,
    output logic             suspended_o
);
    logic preempt;

    dma_preempt_cmp #(.LVL_W(LVL_W)) u_cmp (
        .nmi_i        (nmi_i),
        .irq_level_i  (irq_level_i),
        .supp_level_i (supp_level_i),
        .preempt_o    (preempt)
    );

    dma_hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_req_i  (xfer_req_i),
        .unit_end_i  (unit_end_i),
        .xfer_done_i (xfer_done_i),
        .hold_ack_i  (hold_ack_i),
        .preempt_i   (preempt),
        .hold_req_o  (hold_req_o),
        .grant_o     (grant_o),
        .suspended_o (suspended_o)
    );
endmodule

// File: rtl/dma_bus_hold_chk.sv
module dma_bus_hold_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_req_i,
    input logic             unit_end_i,
    input logic             xfer_done_i,
    input logic             hold_ack_i,
    input logic             nmi_i,
    input logic [LVL_W-1:0] irq_level_i,
    input logic [LVL_W-1:0] supp_level_i,
    input logic             hold_req_o,
    input logic             grant_o,
    input logic             suspended_o
);
    logic hot;
    assign hot = nmi_i || (irq_level_i > supp_level_i);

    assert_grant_under_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> hold_req_o);

    assert_grant_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(hold_ack_i));

    assert_release_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(grant_o) && !$past(xfer_done_i)) |-> ($past(unit_end_i) && suspended_o));

    assert_quiet_irq_keeps_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !hot && !xfer_done_i) |=> grant_o);

    assert_pause_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && hot) |=> suspended_o);

    assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && !hot && !hold_ack_i) |=> (hold_req_o && !suspended_o));

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_o, suspended_o}) && !(hold_req_o && suspended_o));
endmodule

bind dma_bus_hold_ctrl dma_bus_hold_chk #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_req_i   (xfer_req_i),
    .unit_end_i   (unit_end_i),
    .xfer_done_i  (xfer_done_i),
    .hold_ack_i   (hold_ack_i),
    .nmi_i        (nmi_i),
    .irq_level_i  (irq_level_i),
    .supp_level_i (supp_level_i),
    .hold_req_o   (hold_req_o),
    .grant_o      (grant_o),
    .suspended_o  (suspended_o)
);

// File: tb/dma_bus_hold_ctrl_tb.sv
module dma_bus_hold_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, uend = 1'b0, done = 1'b0, ack = 1'b0, nmi = 1'b0;
    logic [LVL_W-1:0] lvl = '0;
    logic [LVL_W-1:0] supp = 4'd4;
    logic hold, grant, susp;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic  h;
        logic  g;
        logic  s;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_bus_hold_ctrl #(.LVL_W(LVL_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_req_i   (req),
        .unit_end_i   (uend),
        .xfer_done_i  (done),
        .hold_ack_i   (ack),
        .nmi_i        (nmi),
        .irq_level_i  (lvl),
        .supp_level_i (supp),
        .hold_req_o   (hold),
        .grant_o      (grant),
        .suspended_o  (susp)
    );

    task automatic compare(input logic h, input logic g, input logic s, input string tag);
        checks++;
        if ({hold, grant, susp} !== {h, g, s}) begin
            fails++;
            $display("FAIL %s: hold/grant/susp actual %b%b%b expected %b%b%b",
                     tag, hold, grant, susp, h, g, s);
        end
    endtask

    // Monitor: each negedge pops the expectation for the edge just passed.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.h, e.g, e.s, e.tag);
            end
        end
    end

    // Driver: apply inputs just after a negedge and queue the outputs due after the next posedge.
    task automatic step(input logic r, input logic u, input logic d, input logic a,
                        input logic n, input logic [LVL_W-1:0] l,
                        input logic eh, input logic eg, input logic es, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        req = r; uend = u; done = d; ack = a; nmi = n; lvl = l;
        e.h = eh; e.g = eg; e.s = es; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare(1'b0, 1'b0, 1'b0, "R1 during reset");
        #1 rst_n = 1'b1;
        @(negedge clk);
        compare(1'b0, 1'b0, 1'b0, "R1 after reset");
        //   req uend done ack nmi lvl   h g s
        step(1, 0, 0, 0, 0, 4'd0, 1, 0, 0, "R2 hold request raised");
        step(1, 0, 0, 0, 0, 4'd0, 1, 0, 0, "R2 waiting for ack");
        step(1, 0, 0, 1, 0, 4'd0, 1, 1, 0, "R2 grant after ack");
        step(1, 0, 0, 1, 0, 4'd4, 1, 1, 0, "R4 equal level ignored");
        step(1, 1, 0, 1, 0, 4'd3, 1, 1, 0, "R4 low level at boundary ignored");
        step(1, 0, 0, 1, 0, 4'd5, 1, 1, 0, "R5 mid-unit keeps grant");
        step(1, 1, 0, 1, 0, 4'd5, 0, 0, 1, "R5 R3 release at boundary");
        step(0, 0, 0, 0, 0, 4'd5, 0, 0, 1, "R7 stays suspended, req dropped");
        step(0, 0, 0, 1, 0, 4'd0, 0, 0, 1, "R10 stale ack blocks resume");
        step(0, 0, 0, 0, 0, 4'd0, 1, 0, 0, "R8 resume request");
        step(0, 0, 0, 1, 0, 4'd0, 1, 1, 0, "R8 regrant after ack");
        step(1, 1, 1, 1, 1, 4'd0, 0, 0, 0, "R9 done wins over boundary");
        step(1, 0, 0, 1, 0, 4'd0, 0, 0, 0, "R10 stale ack blocks new request");
        step(1, 0, 0, 0, 0, 4'd0, 1, 0, 0, "R2 new request");
        step(1, 0, 0, 0, 1, 4'd0, 0, 0, 1, "R6 nmi before grant");
        step(1, 0, 0, 0, 0, 4'd0, 1, 0, 0, "R8 resume after nmi");
        step(1, 0, 0, 1, 0, 4'd0, 1, 1, 0, "R2 grant");
        step(1, 0, 0, 1, 1, 4'd0, 1, 1, 0, "R5 nmi mid-unit");
        step(1, 1, 0, 1, 1, 4'd0, 0, 0, 1, "R5 nmi at boundary");
        step(1, 0, 0, 0, 0, 4'd0, 1, 0, 0, "R8 resume");
        step(1, 0, 0, 1, 0, 4'd0, 1, 1, 0, "R3 grant with hold");
        step(0, 0, 1, 1, 0, 4'd0, 0, 0, 0, "R9 done to idle");
        step(0, 0, 0, 0, 0, 4'd0, 0, 0, 0, "R9 stays idle");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule